// File: doc/BRIEF.md
# Serial CRC-4 Frame Check Generator and Checker

This unit computes a 4-bit cyclic redundancy code one bit per clock over the generator x^4 + x^3 + 1. Both ends of a link run the same unit with the same fixed generator. A sender runs it in generate mode. It feeds the message bits most significant bit first and then receives the 4-bit remainder on a serial output, so that the remainder can follow the data on the line. A receiver runs it in check mode. It feeds the message and the appended remainder, and the unit reports whether the final remainder is nonzero.

A frame opens with a start strobe, which also clears the remainder register. Data bits are counted only in cycles where the valid input is high. A frame closes with an end strobe, and the bit presented in that same cycle, if valid, is the last bit of the frame. The operating mode is captured at the start strobe.

Top module: `crc4_serial`

## Requirements
- R1: While reset is held and in the first cycle after it, `fcs_valid`, `chk_done` and `frame_err` are all 0.
- R2: In generate mode (`chk_mode`=0 at `sof`), `fcs_valid` is 1 for exactly the four cycles after the cycle that carries `eod`, and `fcs_bit` carries the remainder most significant bit first in those cycles. `fcs_bit` is 0 whenever `fcs_valid` is 0. Message 11100110 yields 0110.
- R3: `sof` clears the remainder register, so a frame's result does not depend on any earlier frame. The bit presented with `sof`, if valid, is the first bit of the new frame.
- R4: In check mode (`chk_mode`=1 at `sof`), `chk_done` pulses for exactly one cycle, in the cycle after the `eod` cycle. `frame_err` is 0 when the remainder over all the bits is zero, as it is for 111001100110.
- R5: In check mode, a frame whose remainder is nonzero gives `frame_err`=1. This includes 110001100110, which is the example frame with its third bit inverted.
- R6: Cycles inside a frame where `in_valid` is 0 have no effect on the result.
- R7: `chk_mode` is sampled only at `sof`. A change to it during a frame has no effect on the mode of that frame.
- R8: `in_valid` and `in_bit` are ignored while the remainder is being shifted out.
- R9: `frame_err` holds its value until the next `sof`, and it clears in the cycle after that `sof`.
- R10: A generate-mode frame never raises `chk_done`. A check-mode frame never raises `fcs_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chk_mode | input | 1 | Mode for the frame, sampled at `sof`: 0 generates, 1 checks |
| sof | input | 1 | Start-of-frame strobe; clears the remainder |
| eod | input | 1 | End strobe; marks the last bit of the frame |
| in_valid | input | 1 | `in_bit` carries a frame bit this cycle |
| in_bit | input | 1 | Serial message bit, most significant bit first |
| fcs_valid | output | 1 | A remainder bit is on `fcs_bit` |
| fcs_bit | output | 1 | Serial remainder output |
| chk_done | output | 1 | One-cycle pulse when a check-mode frame completes |
| frame_err | output | 1 | Remainder of the last checked frame was nonzero |

## Verification
The bench builds the unit with its default parameters: a width of 4 and generator taps 1001, which with the implied leading term give x^4+x^3+1. These values make the worked example reachable: the 8-bit message with the known remainder 0110, and the same frame with an inverted bit that the checker must reject. Under this setting, further messages are sent through generate mode and then through check mode with their computed remainder appended. Some of these frames have idle gaps, a mode input that toggles mid-frame, or stray valid bits during the shift-out.

// File: rtl/crc4_pkg.sv
package crc4_pkg;

    // Default generator: x^4 + x^3 + 1, leading term implied.
    localparam int               DEF_CRC_W = 4;
    localparam logic [3:0]       DEF_TAPS  = 4'b1001;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic clear;   // restart remainder at zero
        logic fold;    // absorb din into the remainder
        logic shift;   // move remainder toward the output
        logic din;
    } lfsr_ctl_t;

endpackage

// File: rtl/crc4_ctrl.sv
module crc4_ctrl
    import crc4_pkg::*;
#(
    parameter int CRC_W = DEF_CRC_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sof,
    input  logic      eod,
    input  logic      in_valid,
    input  logic      in_bit,
    input  logic      chk_mode,
    output phase_e    phase,
    output logic      mode_q,
    output lfsr_ctl_t ctl,
    output logic      frame_end
);
    localparam int CNT_W = (CRC_W > 1) ? $clog2(CRC_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CRC_W - 1);

    logic [CNT_W-1:0] emit_cnt;

    always_comb begin
        frame_end = (phase == PH_DATA) && eod && !sof;
        ctl.clear = sof;
        ctl.fold  = in_valid && (sof || phase == PH_DATA);
        ctl.shift = (phase == PH_EMIT) && !sof;
        ctl.din   = in_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            mode_q   <= 1'b0;
            emit_cnt <= '0;
        end else if (sof) begin
            phase    <= PH_DATA;
            mode_q   <= chk_mode;
            emit_cnt <= '0;
        end else begin
            case (phase)
                PH_DATA: if (eod) phase <= mode_q ? PH_IDLE : PH_EMIT;
                PH_EMIT: begin
                    emit_cnt <= emit_cnt + 1'b1;
                    if (emit_cnt == LAST) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crc4_lfsr.sv
module crc4_lfsr
    import crc4_pkg::*;
#(
    parameter int               CRC_W = DEF_CRC_W,
    parameter logic [CRC_W-1:0] TAPS  = DEF_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  lfsr_ctl_t        ctl,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_d
);
    logic [CRC_W-1:0] base;
    logic             fb;

    always_comb begin
        base = ctl.clear ? '0 : crc_q;
        fb   = base[CRC_W-1] ^ ctl.din;
        if (ctl.fold)
            crc_d = {base[CRC_W-2:0], 1'b0} ^ (fb ? TAPS : '0);
        else if (ctl.shift)
            crc_d = {base[CRC_W-2:0], 1'b0};
        else
            crc_d = base;
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= '0;
        else     crc_q <= crc_d;
    end
endmodule

// File: rtl/crc4_serial.sv
module crc4_serial
    import crc4_pkg::*;
#(
    parameter int               CRC_W = DEF_CRC_W,
    parameter logic [CRC_W-1:0] TAPS  = DEF_TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic chk_mode,
    input  logic sof,
    input  logic eod,
    input  logic in_valid,
    input  logic in_bit,
    output logic fcs_valid,
    output logic fcs_bit,
    output logic chk_done,
    output logic frame_err
);
    phase_e           phase;
    logic             mode_q;
    logic             frame_end;
    lfsr_ctl_t        ctl;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_d;

    crc4_ctrl #(.CRC_W(CRC_W)) u_ctrl (
        .clk(clk), .rst(rst), .sof(sof), .eod(eod),
        .in_valid(in_valid), .in_bit(in_bit), .chk_mode(chk_mode),
        .phase(phase), .mode_q(mode_q), .ctl(ctl), .frame_end(frame_end)
    );

    crc4_lfsr #(.CRC_W(CRC_W), .TAPS(TAPS)) u_lfsr (
        .clk(clk), .rst(rst), .ctl(ctl), .crc_q(crc_q), .crc_d(crc_d)
    );

    assign fcs_valid = (phase == PH_EMIT);
    assign fcs_bit   = fcs_valid & crc_q[CRC_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_done  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            chk_done <= frame_end && mode_q;
            if (sof)
                frame_err <= 1'b0;
            else if (frame_end && mode_q)
                frame_err <= |crc_d;
        end
    end
endmodule

// File: rtl/crc4_serial_chk.sv
module crc4_serial_chk #(
    parameter int CRC_W = 4
) (
    input logic clk,
    input logic rst,
    input logic sof,
    input logic eod,
    input logic fcs_valid,
    input logic fcs_bit,
    input logic chk_done,
    input logic frame_err
);
    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (fcs_valid) run_len <= (run_len == 8'hFF) ? run_len : run_len + 1'b1;
        else                run_len <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fcs_valid && !chk_done && !frame_err));

    assert_emit_len_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(fcs_valid) && !$past(sof)) |-> (run_len == 8'(CRC_W)));

    assert_bit_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !fcs_valid |-> !fcs_bit);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        chk_done |=> !chk_done);

    assert_done_after_eod_R4: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> $past(eod));

    assert_err_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_err) |-> (chk_done || $past(sof)));

    assert_mode_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(fcs_valid && chk_done));
endmodule

bind crc4_serial crc4_serial_chk #(.CRC_W(CRC_W)) u_chk (
    .clk(clk), .rst(rst), .sof(sof), .eod(eod),
    .fcs_valid(fcs_valid), .fcs_bit(fcs_bit),
    .chk_done(chk_done), .frame_err(frame_err)
);

// File: tb/crc4_serial_tb.sv
module crc4_serial_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chk_mode = 1'b0;
    logic sof = 1'b0;
    logic eod = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic fcs_valid, fcs_bit, chk_done, frame_err;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    crc4_serial u_dut (
        .clk(clk), .rst(rst), .chk_mode(chk_mode), .sof(sof), .eod(eod),
        .in_valid(in_valid), .in_bit(in_bit), .fcs_valid(fcs_valid),
        .fcs_bit(fcs_bit), .chk_done(chk_done), .frame_err(frame_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference remainder by long division of msg * x^4 by 11001.
    function automatic logic [3:0] ref_crc(input logic [15:0] bits, input int n);
        logic [4:0] rem = '0;
        for (int i = n + 3; i >= 0; i--) begin
            rem = {rem[3:0], (i >= 4) ? bits[i-4] : 1'b0};
            if (rem[4]) rem = rem ^ 5'b11001;
        end
        return rem[3:0];
    endfunction

    task automatic run_frame(input logic [15:0] bits, input int n, input logic mode,
                             input logic eod_last, input logic gaps, input logic flip);
        for (int i = n - 1; i >= 0; i--) begin
            sof      = (i == n - 1);
            eod      = eod_last && (i == 0);
            in_valid = 1'b1;
            in_bit   = bits[i];
            if (i == n - 1) chk_mode = mode;
            tick();
            sof = 1'b0;
            eod = 1'b0;
            if (flip) chk_mode = ~mode;
            if (gaps && i != 0) begin
                in_valid = 1'b0;
                in_bit   = 1'b1;
                tick();
            end
        end
        in_valid = 1'b0;
        in_bit   = 1'b0;
        if (!eod_last) begin
            eod = 1'b1;
            tick();
            eod = 1'b0;
        end
    endtask

    task automatic expect_fcs(input logic [3:0] exp, input logic junk, input string req);
        for (int i = 3; i >= 0; i--) begin
            chk(16'(fcs_valid), 16'd1, req, "fcs_valid in window");
            chk(16'(fcs_bit), 16'(exp[i]), req, "fcs_bit");
            chk(16'(chk_done), 16'd0, "R10", "chk_done in generate mode");
            if (junk) begin in_valid = 1'b1; in_bit = 1'b1; end
            tick();
        end
        in_valid = 1'b0;
        in_bit   = 1'b0;
        chk(16'(fcs_valid), 16'd0, req, "fcs_valid after window");
        chk(16'(fcs_bit), 16'd0, "R2", "fcs_bit idle");
    endtask

    task automatic expect_check(input logic exp_err, input string req);
        chk(16'(chk_done), 16'd1, req, "chk_done pulse");
        chk(16'(frame_err), 16'(exp_err), req, "frame_err");
        chk(16'(fcs_valid), 16'd0, "R10", "fcs_valid in check mode");
        tick();
        chk(16'(chk_done), 16'd0, "R4", "chk_done one cycle");
        chk(16'(frame_err), 16'(exp_err), "R9", "frame_err held");
    endtask

    task automatic t_reset();
        chk(16'(fcs_valid), 16'd0, "R1", "fcs_valid in reset");
        chk(16'(chk_done), 16'd0, "R1", "chk_done in reset");
        chk(16'(frame_err), 16'd0, "R1", "frame_err in reset");
        rst = 1'b0;
        tick();
        chk(16'(fcs_valid), 16'd0, "R1", "fcs_valid after reset");
        chk(16'(chk_done), 16'd0, "R1", "chk_done after reset");
        chk(16'(frame_err), 16'd0, "R1", "frame_err after reset");
    endtask

    task automatic t_gen_example();
        chk(16'(ref_crc(16'h00E6, 8)), 16'h6, "R2", "reference model 0110");
        run_frame(16'h00E6, 8, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_fcs(4'b0110, 1'b0, "R2");
    endtask

    task automatic t_back_to_back();
        // R3: previous remainder must not leak into the next frame
        run_frame(16'h000F, 4, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fcs(ref_crc(16'h000F, 4), 1'b0, "R3");
        run_frame(16'h00E6, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_fcs(4'b0110, 1'b0, "R3");
    endtask

    task automatic t_check_example();
        run_frame(16'h0E66, 12, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_check(1'b0, "R4");
        run_frame(16'h0C66, 12, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_check(1'b1, "R5");
    endtask

    task automatic t_err_hold();
        // R9: still set from the corrupted frame
        repeat (3) tick();
        chk(16'(frame_err), 16'd1, "R9", "frame_err held while idle");
        sof = 1'b1;
        tick();
        sof = 1'b0;
        chk(16'(frame_err), 16'd0, "R9", "frame_err cleared by sof");
    endtask

    task automatic t_gaps();
        run_frame(16'h0E66, 12, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_check(1'b0, "R6");
        run_frame(16'h00E6, 8, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_fcs(4'b0110, 1'b0, "R6");
    endtask

    task automatic t_mode_latch();
        run_frame(16'h00E6, 8, 1'b0, 1'b1, 1'b0, 1'b1);
        expect_fcs(4'b0110, 1'b0, "R7");
        run_frame(16'h0C66, 12, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_check(1'b1, "R7");
    endtask

    task automatic t_emit_ignore();
        run_frame(16'h00E6, 8, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_fcs(4'b0110, 1'b1, "R8");
    endtask

    task automatic t_sweep();
        logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5E};
        foreach (pats[k]) begin
            logic [3:0] r = ref_crc(16'(pats[k]), 8);
            run_frame(16'(pats[k]), 8, 1'b0, 1'b0, 1'b0, 1'b0);
            expect_fcs(r, 1'b0, "R2");
            run_frame({4'h0, pats[k], r}, 12, 1'b1, 1'b1, 1'b0, 1'b0);
            expect_check(1'b0, "R4");
            run_frame({4'h0, pats[k] ^ 8'h10, r}, 12, 1'b1, 1'b1, 1'b0, 1'b0);
            expect_check(1'b1, "R5");
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        t_gen_example();
        t_back_to_back();
        t_check_example();
        t_err_hold();
        t_gaps();
        t_mode_latch();
        t_emit_ignore();
        t_sweep();
        repeat (2) tick();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end
endmodule